// File: doc/BRIEF.md
# Jitter-Sampling XOR Decimator

This block is the digital back end of a clock-jitter random bit source. A free-running, jittered clock from an on-chip PLL is fed in as a one-bit input, `jitIn`. A single flip-flop clocked by the reference clock samples it every cycle. No synchronizer follows, because the unsettled samples taken near the jittered edges are what carries the entropy. A short tapped delay line XORs the newest sample with its predecessors at full rate; this is the corrector. An accumulator then folds every `DECIM_RATIO` corrected samples into one output bit.

The decimation ratio is meant to equal the denominator of the clock ratio F_jit / F_ref = M / DECIM_RATIO, with M and DECIM_RATIO coprime. Each output bit then covers exactly one beat period, and the sampling phases over that window repeat in a fixed pattern. Any part of the sampled signal that is periodic with the beat period therefore contributes the same value to every window, and only the samples taken near jittered edges make the output bits differ from one another. The default ratio is 1272; a small setting such as 7 (with M = 5) suits short runs. Decimated bits appear on a one-cycle strobe. A packer groups them into bytes for a valid/ready sink and keeps a sticky flag when bits are lost because the sink stalls.

Top module: `jitter_xor_decimator`

## Requirements
- R1: While `rst` is high at a clock edge, the sampler, corrector line, window counter, accumulator and packer are cleared. Afterwards `randValid`, `randBit`, `byteValid`, `byteData` and `overflow` read 0.
- R2: Number the rising edges after reset from 1. `randValid` is high for exactly one cycle after edges DECIM_RATIO, 2·DECIM_RATIO, and so on, and low after every other edge.
- R3: The bit presented with the n-th strobe is the XOR of the corrected samples c_j for j = (n−1)·DECIM_RATIO … n·DECIM_RATIO−1, where c_0 = 0.
- R4: With corrector depth D, c_j = s_j ^ s_(j−1) ^ … ^ s_(j−D+1), where samples of index 0 or below count as 0. Depth 1 passes the raw samples through.
- R5: s_j is the value of `jitIn` at edge j, taken by a single register with no added synchronizer stages.
- R6: Decimated bits are packed 8 to a byte, with the earliest bit in bit 7. `byteValid` rises in the cycle after the strobe that carries the eighth bit.
- R7: While `byteValid` is high and `byteReady` is low, `byteValid` stays high and `byteData` does not change.
- R8: After a cycle in which `byteValid` and `byteReady` are both high, `byteValid` is low unless a new byte completes in that same cycle.
- R9: A strobe that arrives while a byte is held and `byteReady` is low is dropped: it never appears in a later byte. It also sets `overflow`, which stays high until reset.
- R10: A reset applied mid-run restarts the window count, so the first strobe after it follows R2 counted from the new reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| jitIn | input | 1 | Jittered clock, sampled asynchronously |
| randValid | output | 1 | One-cycle strobe marking a decimated bit |
| randBit | output | 1 | Decimated random bit |
| byteReady | input | 1 | Sink can accept the held byte |
| byteValid | output | 1 | A packed byte is held on byteData |
| byteData | output | 8 | Packed byte, earliest bit in the MSB |
| overflow | output | 1 | Sticky flag: a bit was dropped while the sink stalled |

## Verification
Three instances run side by side with depth 1, 2 and 3 and with different ratios. An alternating stream makes every depth-2 corrected sample 1, so the window parity exposes an off-by-one window. A constant-high stream leaves only the first transition visible and so pins the window boundaries and the reset values of the delay line. A stream that repeats with the decimation period shows that the depth-1 windows all agree. A pseudo-random stream tests the window XOR as a whole. A stalled sink with a one-cycle release, and a reset in the middle of a window, exercise packer drops, the hold behaviour and the window restart.

// File: rtl/jxd_pkg.sv
package jxd_pkg;

  // Strobes from the control to the datapath, one per cycle
  typedef struct packed {
    logic windowEnd;  // last sample of the current decimation window
    logic shiftIn;    // push the presented decimated bit into the packer
    logic loadByte;   // the pushed bit completes a byte; latch it
  } jxdStrobes_t;

endpackage

// File: rtl/jxd_control.sv
module jxd_control
  import jxd_pkg::*;
#(
  parameter int DECIM_RATIO = 1272,
  parameter int PACK_W      = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byteReady,
  output jxdStrobes_t strobes,
  output logic        randValid,
  output logic        byteValid,
  output logic        overflow
);

  localparam int CNT_W = (DECIM_RATIO > 1) ? $clog2(DECIM_RATIO) : 1;
  localparam int BIT_W = (PACK_W > 1) ? $clog2(PACK_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECIM_RATIO - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(PACK_W - 1);

  logic [CNT_W-1:0] winCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             accept;
  logic             lastBit;

  // Packer may take a bit when no byte is held or the held one leaves now
  assign accept  = randValid && (!byteValid || byteReady);
  assign lastBit = (bitCnt == BIT_LAST);

  assign strobes.windowEnd = (winCnt == CNT_LAST);
  assign strobes.shiftIn   = accept;
  assign strobes.loadByte  = accept && lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt    <= '0;
      randValid <= 1'b0;
    end else begin
      winCnt    <= strobes.windowEnd ? '0 : winCnt + 1'b1;
      randValid <= strobes.windowEnd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt    <= '0;
      byteValid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (accept) begin
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (strobes.loadByte) begin
        byteValid <= 1'b1;
      end else if (byteReady) begin
        byteValid <= 1'b0;
      end
      if (randValid && byteValid && !byteReady) begin
        overflow <= 1'b1;
      end
    end
  end

  assert_window_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    winCnt <= CNT_LAST);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    randValid |=> !randValid);

  assert_byte_held_R7: assert property (@(posedge clk) disable iff (rst)
    (byteValid && !byteReady) |=> byteValid);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

endmodule

// File: rtl/jxd_datapath.sv
module jxd_datapath
  import jxd_pkg::*;
#(
  parameter int CORR_DEPTH = 2,
  parameter int PACK_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jitIn,
  input  jxdStrobes_t       strobes,
  output logic              randBit,
  output logic [PACK_W-1:0] byteData
);

  logic              sampleQ;
  logic              corrected;
  logic              accum;
  logic [PACK_W-1:0] shiftReg;
  logic [PACK_W-1:0] nextShift;

  // Single sampling register; metastability here is the entropy source
  always_ff @(posedge clk) begin
    if (rst) sampleQ <= 1'b0;
    else     sampleQ <= jitIn;
  end

  generate
    if (CORR_DEPTH > 1) begin : g_corrector
      logic [CORR_DEPTH-2:0] delayLine;
      always_ff @(posedge clk) begin
        if (rst) begin
          delayLine <= '0;
        end else begin
          delayLine[0] <= sampleQ;
          for (int i = 1; i < CORR_DEPTH - 1; i++) begin
            delayLine[i] <= delayLine[i-1];
          end
        end
      end
      assign corrected = sampleQ ^ (^delayLine);
    end else begin : g_bypass
      assign corrected = sampleQ;
    end
  endgenerate

  // Modulo-2 accumulation over one decimation window
  always_ff @(posedge clk) begin
    if (rst) begin
      accum   <= 1'b0;
      randBit <= 1'b0;
    end else if (strobes.windowEnd) begin
      accum   <= 1'b0;
      randBit <= accum ^ corrected;
    end else begin
      accum   <= accum ^ corrected;
    end
  end

  assign nextShift = {shiftReg[PACK_W-2:0], randBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      byteData <= '0;
    end else begin
      if (strobes.shiftIn)  shiftReg <= nextShift;
      if (strobes.loadByte) byteData <= nextShift;
    end
  end

endmodule

// File: rtl/jitter_xor_decimator.sv
module jitter_xor_decimator
  import jxd_pkg::*;
#(
  parameter int DECIM_RATIO = 1272,
  parameter int CORR_DEPTH  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       jitIn,
  output logic       randValid,
  output logic       randBit,
  input  logic       byteReady,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       overflow
);

  localparam int PACK_W = 8;

  jxdStrobes_t strobes;

  jxd_control #(
    .DECIM_RATIO(DECIM_RATIO),
    .PACK_W     (PACK_W)
  ) u_control (
    .clk      (clk),
    .rst      (rst),
    .byteReady(byteReady),
    .strobes  (strobes),
    .randValid(randValid),
    .byteValid(byteValid),
    .overflow (overflow)
  );

  jxd_datapath #(
    .CORR_DEPTH(CORR_DEPTH),
    .PACK_W    (PACK_W)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .jitIn   (jitIn),
    .strobes (strobes),
    .randBit (randBit),
    .byteData(byteData)
  );

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (byteValid && !byteReady) |=> $stable(byteData));

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!randValid && !byteValid && !overflow));

endmodule

// File: tb/jitter_xor_decimator_bench.sv
module jitter_xor_decimator_bench;

  localparam int K1 = 7, D1 = 2;
  localparam int K2 = 5, D2 = 1;
  localparam int K3 = 6, D3 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic jitIn = 1'b0;
  logic byteReady = 1'b0;

  logic v1, b1, bv1, ov1;  logic [7:0] bd1;
  logic v2, b2, bv2, ov2;  logic [7:0] bd2;
  logic v3, b3, bv3, ov3;  logic [7:0] bd3;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  bit sLog [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  always #5 clk = ~clk;

  jitter_xor_decimator #(.DECIM_RATIO(K1), .CORR_DEPTH(D1)) u_jitter_xor_decimator (
    .clk(clk), .rst(rst), .jitIn(jitIn), .randValid(v1), .randBit(b1),
    .byteReady(byteReady), .byteValid(bv1), .byteData(bd1), .overflow(ov1));

  jitter_xor_decimator #(.DECIM_RATIO(K2), .CORR_DEPTH(D2)) u_bypass (
    .clk(clk), .rst(rst), .jitIn(jitIn), .randValid(v2), .randBit(b2),
    .byteReady(byteReady), .byteValid(bv2), .byteData(bd2), .overflow(ov2));

  jitter_xor_decimator #(.DECIM_RATIO(K3), .CORR_DEPTH(D3)) u_deep (
    .clk(clk), .rst(rst), .jitIn(jitIn), .randValid(v3), .randBit(b3),
    .byteReady(byteReady), .byteValid(bv3), .byteData(bd3), .overflow(ov3));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, edgeCnt);
    end
  endtask

  // Corrected sample c_j per R4, with samples at index <= 0 taken as 0
  function automatic bit corrAt(input int j, input int d);
    bit x = 1'b0;
    for (int t = 0; t < d; t++) begin
      if (j - t >= 1) x ^= sLog[j - t];
    end
    return x;
  endfunction

  // Window n per R3
  function automatic bit winBit(input int n, input int k, input int d);
    bit x = 1'b0;
    for (int j = (n - 1) * k; j < n * k; j++) x ^= corrAt(j, d);
    return x;
  endfunction

  function automatic logic [7:0] packExp(input int first);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7 - i] = winBit(first + i, K1, D1);
    return r;
  endfunction

  function automatic bit lfsrBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic checkInst(input int k, input int d, input logic v, input logic b,
                           input string tag);
    bit expV = (edgeCnt % k == 0);
    check(v === expV, {"R2 strobe ", tag}, v, expV);
    if (expV) check(b === winBit(edgeCnt / k, k, d), {"R3/R4/R5 bit ", tag}, b,
                    winBit(edgeCnt / k, k, d));
  endtask

  // Drive one sample (seen at the next edge), then check at the falling edge
  task automatic stepBit(input bit b, input bit rdy);
    jitIn = b;
    byteReady = rdy;
    edgeCnt++;
    sLog[edgeCnt] = b;
    @(posedge clk);
    @(negedge clk);
    checkInst(K1, D1, v1, b1, "depth2");
    checkInst(K2, D2, v2, b2, "depth1");
    checkInst(K3, D3, v3, b3, "depth3");
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; jitIn = 1'b0; byteReady = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    edgeCnt = 0;
  endtask

  task automatic testResetState();
    doReset();
    check(v1 === 1'b0,     "R1 randValid", v1, 0);
    check(b1 === 1'b0,     "R1 randBit", b1, 0);
    check(bv1 === 1'b0,    "R1 byteValid", bv1, 0);
    check(bd1 === 8'h00,   "R1 byteData", bd1, 0);
    check(ov1 === 1'b0,    "R1 overflow", ov1, 0);
  endtask

  task automatic testAlternating();   // R3, R4: every depth-2 corrected sample is 1
    doReset();
    for (int i = 0; i < 6 * K1; i++) stepBit(i[0], 1'b1);
  endtask

  task automatic testConstantHigh();  // R4, R5: only the first transition survives
    doReset();
    for (int i = 0; i < 5 * K1; i++) stepBit(1'b1, 1'b1);
  endtask

  task automatic testPeriodic();      // R3: pattern periodic in K2 gives equal depth-1 windows
    bit first;
    doReset();
    for (int i = 0; i < 6 * K2; i++) begin
      stepBit((i % K2) inside {0, 2, 3}, 1'b1);
      if (edgeCnt == K2) first = b2;
      if (edgeCnt > K2 && edgeCnt % K2 == 0)
        check(b2 === first, "R3 periodic windows equal", b2, first);
    end
  endtask

  task automatic testRandom();
    doReset();
    for (int i = 0; i < 12 * K1; i++) stepBit(lfsrBit(), 1'b1);
  endtask

  task automatic testMidReset();      // R10
    doReset();
    for (int i = 0; i < 10; i++) stepBit(lfsrBit(), 1'b1);
    doReset();
    check(v1 === 1'b0, "R10 no strobe right after reset", v1, 0);
    for (int i = 0; i < 3 * K1; i++) stepBit(lfsrBit(), 1'b1);
  endtask

  task automatic testPacker();        // R6, R7, R8, R9
    logic [7:0] held;
    doReset();
    while (edgeCnt < 19 * K1 + 1) begin
      stepBit(lfsrBit(), (edgeCnt == 11 * K1 + 2));
      if (edgeCnt == 8 * K1)
        check(bv1 === 1'b0, "R6 no byte before eighth bit", bv1, 0);
      if (edgeCnt == 8 * K1 + 1) begin
        check(bv1 === 1'b1, "R6 byteValid", bv1, 1);
        check(bd1 === packExp(1), "R6 byte MSB-first", bd1, packExp(1));
        held = bd1;
      end
      if (edgeCnt == 11 * K1 + 2) begin
        check(bv1 === 1'b1, "R7 byte held while stalled", bv1, 1);
        check(bd1 === held, "R7 byteData stable", bd1, held);
        check(ov1 === 1'b1, "R9 overflow set", ov1, 1);
      end
      if (edgeCnt == 11 * K1 + 3)
        check(bv1 === 1'b0, "R8 byteValid cleared after handshake", bv1, 0);
    end
    check(bv1 === 1'b1, "R9 next byte valid", bv1, 1);
    check(bd1 === packExp(12), "R9 dropped bits absent", bd1, packExp(12));
    check(ov1 === 1'b1, "R9 overflow sticky", ov1, 1);
  endtask

  initial begin
    testResetState();
    testAlternating();
    testConstantHigh();
    testPeriodic();
    testRandom();
    testMidReset();
    testPacker();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule